// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the single state bit of a programmable-logic macrocell. A mode field turns it into a D, toggle, JK or set/reset flip-flop, or into a flow-through latch. The data bit can come from three places: the sum-of-products logic path, a dedicated product term, or the I/O pin. A second term supplies the K or R input in the two-input modes. The element is clocked by one of several global clocks or by a private product-term clock. An enable term can gate the global clocks.

An asynchronous clear and an asynchronous preset override the stored value. The clear can come from a shared global line, from a local term, or from both ORed together. A buried feedback output gives the logic array either the stored value or the raw logic-path value.

The element runs inside a fast system clock domain. The global clocks and the term clock are treated as level inputs and sampled there, and a rising edge is a low-to-high change between two samples. The asynchronous controls and the latch flow-through act on the output without waiting for a system clock edge.

Top module: `mc_store`

## Requirements
- R1: While `rst_n` is low, `q` is 0. A selected clock that is already high when reset is released produces no capture until it has been seen low.
- R2: With `modeSel` = 0, or any unused code 5 to 7, the element is a D flip-flop. It loads the selected data bit on a rising edge of the selected clock, and `q` shows the new value one system cycle after the clock input rises.
- R3: With `modeSel` = 1 (toggle), a rising edge inverts `q` when the data bit is 1 and leaves `q` unchanged when it is 0.
- R4: With `modeSel` = 2 (JK), the data bit acts as J and `auxIn` as K. On a rising edge: J=1,K=0 sets; J=0,K=1 clears; both 1 toggles; both 0 holds.
- R5: With `modeSel` = 3 (SR), the data bit acts as S and `auxIn` as R. On a rising edge: S=1,R=0 sets; R=1 clears, including when S is also 1; both 0 holds.
- R6: With `modeSel` = 4 (latch), `q` follows the data bit at once while the selected clock is high. When the clock falls, `q` keeps the value the data bit had during the high phase.
- R7: `clkSel` values 0 to NUM_GCLK-1 pick the matching bit of `gclk`, and the value NUM_GCLK picks `ptClk`. Only the picked clock affects the element.
- R8: When `ceUse` is 1, `ceIn` is 0 and a global clock is selected, rising edges are ignored and the latch stays closed. With `ptClk` selected, `ceUse` and `ceIn` have no effect.
- R9: `dataSrc` 0 picks `xorIn`, 1 picks `termIn`, 2 picks `pinIn`, and 3 falls back to `xorIn`.
- R10: The clear is active as follows, by `clrSel`: 0 never; 1 on `gClear`; 2 on `clrTerm`; 3 on either of them. While it is active, `q` is 0 at once and clock edges are not captured.
- R11: When `preUse` and `preTerm` are both 1, `q` is 1 at once, and it stays 1 after the preset is released.
- R12: When clear and preset are active together, `q` is 0. If the clear is released while the preset stays active, `q` becomes 1.
- R13: `fb` equals `xorIn` when `fbSel` is 1, and equals `q` when `fbSel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset, clears the element |
| modeSel | input | 3 | Storage mode: 0 D, 1 toggle, 2 JK, 3 SR, 4 latch, 5-7 D |
| dataSrc | input | 2 | Data bit source: 0 logic path, 1 term, 2 pin, 3 logic path |
| xorIn | input | 1 | Logic-path (XOR output) value |
| termIn | input | 1 | Dedicated data product term |
| pinIn | input | 1 | Direct pin value |
| auxIn | input | 1 | K input in JK mode, R input in SR mode |
| gclk | input | NUM_GCLK | Global clock lines |
| ptClk | input | 1 | Product-term clock |
| clkSel | input | clog2(NUM_GCLK+1) | Clock choice, NUM_GCLK selects ptClk |
| ceUse | input | 1 | Clock enable in use (global clocks only) |
| ceIn | input | 1 | Clock enable term |
| clrSel | input | 2 | Clear source: 0 off, 1 global, 2 term, 3 both |
| gClear | input | 1 | Global clear line |
| clrTerm | input | 1 | Clear product term |
| preUse | input | 1 | Preset term in use |
| preTerm | input | 1 | Preset product term |
| fbSel | input | 1 | Feedback choice: 0 stored value, 1 logic path |
| q | output | 1 | Element output |
| fb | output | 1 | Buried feedback to the logic array |

## Verification
A rising edge of the selected clock can arrive while an asynchronous clear is held. The bench raises the clock and the global clear on the same drive edge, with a data bit of 1. It requires `q` to stay 0 both during the pulse and after both are released. The clear and the preset are also raised together: the bench expects 0 while both are active and 1 as soon as only the clear is dropped. A random phase applies clock pulses in every mode and inserts clear pulses between them. Each result is compared against a reference model kept in the bench.

// File: rtl/mc_store_pkg.sv
package mc_store_pkg;

  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } reg_mode_e;

  typedef enum logic [1:0] {
    SRC_LOGIC = 2'd0,
    SRC_TERM  = 2'd1,
    SRC_PIN   = 2'd2,
    SRC_ALT   = 2'd3
  } dsrc_e;

  // strobes from control to datapath
  typedef struct packed {
    reg_mode_e mode;
    logic      tick;   // qualified rising edge
    logic      open;   // latch transparent
    logic      clr;    // async clear (includes reset)
    logic      pre;    // async preset
  } cell_strobe_t;

endpackage

// File: rtl/mc_store_ctrl.sv
module mc_store_ctrl
  import mc_store_pkg::*;
#(
  parameter int NUM_GCLK = 3,
  localparam int CLK_SRC = NUM_GCLK + 1,
  localparam int CSEL_W  = $clog2(CLK_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          modeSel,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                ptClk,
  input  logic [CSEL_W-1:0]   clkSel,
  input  logic                ceUse,
  input  logic                ceIn,
  input  logic [1:0]          clrSel,
  input  logic                gClear,
  input  logic                clrTerm,
  input  logic                preUse,
  input  logic                preTerm,
  output cell_strobe_t        stb
);

  logic [CLK_SRC-1:0] srcVec;
  logic [CLK_SRC-1:0] srcHit;
  logic               selLvl;
  logic               prevLvl;
  logic               isGlobal;
  logic               enOk;
  reg_mode_e          modeDec;

  assign srcVec = {ptClk, gclk};

  // one comparator per clock source
  for (genvar i = 0; i < CLK_SRC; i++) begin : g_clkpick
    assign srcHit[i] = (clkSel == CSEL_W'(i)) & srcVec[i];
  end

  assign selLvl   = |srcHit;
  assign isGlobal = (clkSel < CSEL_W'(NUM_GCLK));
  assign enOk     = ~(ceUse & isGlobal) | ceIn;

  // previous sample; reset high so a clock held high gives no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLvl <= 1'b1;
    else        prevLvl <= selLvl;
  end

  always_comb begin
    if (modeSel <= 3'd4) modeDec = reg_mode_e'(modeSel);
    else                 modeDec = MODE_D;
  end

  always_comb begin
    stb.mode = modeDec;
    stb.tick = selLvl & ~prevLvl & enOk & (modeDec != MODE_LATCH);
    stb.open = selLvl & enOk & (modeDec == MODE_LATCH);
    stb.clr  = ~rst_n | (clrSel[0] & gClear) | (clrSel[1] & clrTerm);
    stb.pre  = preUse & preTerm;
  end

endmodule

// File: rtl/mc_store_dp.sv
module mc_store_dp
  import mc_store_pkg::*;
(
  input  logic         clk,
  input  cell_strobe_t stb,
  input  logic [1:0]   dataSrc,
  input  logic         xorIn,
  input  logic         termIn,
  input  logic         pinIn,
  input  logic         auxIn,
  input  logic         fbSel,
  output logic         q,
  output logic         fb
);

  logic dSel;
  logic nextVal;
  logic stateBit;
  logic aClr;
  logic aPre;
  logic loadNow;

  assign aClr    = stb.clr;
  assign aPre    = stb.pre;
  assign loadNow = stb.tick | stb.open;

  always_comb begin
    case (dsrc_e'(dataSrc))
      SRC_TERM: dSel = termIn;
      SRC_PIN:  dSel = pinIn;
      default:  dSel = xorIn;
    endcase
  end

  always_comb begin
    case (stb.mode)
      MODE_T:  nextVal = stateBit ^ dSel;
      MODE_JK: begin
        case ({dSel, auxIn})
          2'b10:   nextVal = 1'b1;
          2'b01:   nextVal = 1'b0;
          2'b11:   nextVal = ~stateBit;
          default: nextVal = stateBit;
        endcase
      end
      MODE_SR: begin
        if (auxIn)     nextVal = 1'b0;
        else if (dSel) nextVal = 1'b1;
        else           nextVal = stateBit;
      end
      default: nextVal = dSel;
    endcase
  end

  always_ff @(posedge clk or posedge aClr or posedge aPre) begin
    if (aClr)         stateBit <= 1'b0;
    else if (aPre)    stateBit <= 1'b1;
    else if (loadNow) stateBit <= nextVal;
  end

  // asynchronous overrides and flow-through act without a clock
  always_comb begin
    if (aClr)          q = 1'b0;
    else if (aPre)     q = 1'b1;
    else if (stb.open) q = dSel;
    else               q = stateBit;
  end

  assign fb = fbSel ? xorIn : q;

endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_store_pkg::*;
#(
  parameter int NUM_GCLK = 3,
  localparam int CSEL_W  = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          modeSel,
  input  logic [1:0]          dataSrc,
  input  logic                xorIn,
  input  logic                termIn,
  input  logic                pinIn,
  input  logic                auxIn,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                ptClk,
  input  logic [CSEL_W-1:0]   clkSel,
  input  logic                ceUse,
  input  logic                ceIn,
  input  logic [1:0]          clrSel,
  input  logic                gClear,
  input  logic                clrTerm,
  input  logic                preUse,
  input  logic                preTerm,
  input  logic                fbSel,
  output logic                q,
  output logic                fb
);

  cell_strobe_t stb;

  mc_store_ctrl #(.NUM_GCLK(NUM_GCLK)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .modeSel (modeSel),
    .gclk    (gclk),
    .ptClk   (ptClk),
    .clkSel  (clkSel),
    .ceUse   (ceUse),
    .ceIn    (ceIn),
    .clrSel  (clrSel),
    .gClear  (gClear),
    .clrTerm (clrTerm),
    .preUse  (preUse),
    .preTerm (preTerm),
    .stb     (stb)
  );

  mc_store_dp u_dp (
    .clk     (clk),
    .stb     (stb),
    .dataSrc (dataSrc),
    .xorIn   (xorIn),
    .termIn  (termIn),
    .pinIn   (pinIn),
    .auxIn   (auxIn),
    .fbSel   (fbSel),
    .q       (q),
    .fb      (fb)
  );

endmodule

// File: rtl/mc_store_chk.sv
module mc_store_chk #(
  parameter int NUM_GCLK = 3,
  localparam int CSEL_W  = $clog2(NUM_GCLK + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        modeSel,
  input logic [CSEL_W-1:0] clkSel,
  input logic              ceUse,
  input logic              ceIn,
  input logic [1:0]        clrSel,
  input logic              gClear,
  input logic              clrTerm,
  input logic              preUse,
  input logic              preTerm,
  input logic              fbSel,
  input logic              xorIn,
  input logic              q,
  input logic              fb
);

  logic clrNow;
  logic preNow;
  logic ceBlocked;

  assign clrNow    = (clrSel[0] & gClear) | (clrSel[1] & clrTerm);
  assign preNow    = preUse & preTerm;
  assign ceBlocked = ceUse & ~ceIn & (clkSel < CSEL_W'(NUM_GCLK))
                   & (modeSel != 3'd4) & ~clrNow & ~preNow;

  assert_clear_forces_low_R10: assert property (
    @(posedge clk) disable iff (!rst_n) clrNow |-> (q == 1'b0));

  assert_preset_forces_high_R11: assert property (
    @(posedge clk) disable iff (!rst_n) (preNow && !clrNow) |-> (q == 1'b1));

  assert_clear_beats_preset_R12: assert property (
    @(posedge clk) disable iff (!rst_n) (preNow && clrNow) |-> (q == 1'b0));

  assert_enable_blocks_edges_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      ceBlocked |=> (clrNow || preNow || modeSel == 3'd4 || q == $past(q)));

  assert_feedback_logic_R13: assert property (
    @(posedge clk) disable iff (!rst_n) fbSel |-> (fb == xorIn));

  assert_feedback_state_R13: assert property (
    @(posedge clk) disable iff (!rst_n) !fbSel |-> (fb == q));

endmodule

bind mc_store mc_store_chk #(.NUM_GCLK(NUM_GCLK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .modeSel (modeSel),
  .clkSel  (clkSel),
  .ceUse   (ceUse),
  .ceIn    (ceIn),
  .clrSel  (clrSel),
  .gClear  (gClear),
  .clrTerm (clrTerm),
  .preUse  (preUse),
  .preTerm (preTerm),
  .fbSel   (fbSel),
  .xorIn   (xorIn),
  .q       (q),
  .fb      (fb)
);

// File: tb/mc_store_test.sv
module mc_store_test;

  localparam int NG = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [1:0] dataSrc = 2'd0;
  logic       xorIn = 1'b0, termIn = 1'b0, pinIn = 1'b0, auxIn = 1'b0;
  logic [NG-1:0] gclk = '0;
  logic       ptClk = 1'b0;
  logic [1:0] clkSel = 2'd0;
  logic       ceUse = 1'b0, ceIn = 1'b0;
  logic [1:0] clrSel = 2'd0;
  logic       gClear = 1'b0, clrTerm = 1'b0, preUse = 1'b0, preTerm = 1'b0;
  logic       fbSel = 1'b0;
  logic       q, fb;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  mc_store #(.NUM_GCLK(NG)) uut (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .dataSrc(dataSrc),
    .xorIn(xorIn), .termIn(termIn), .pinIn(pinIn), .auxIn(auxIn),
    .gclk(gclk), .ptClk(ptClk), .clkSel(clkSel), .ceUse(ceUse), .ceIn(ceIn),
    .clrSel(clrSel), .gClear(gClear), .clrTerm(clrTerm), .preUse(preUse),
    .preTerm(preTerm), .fbSel(fbSel), .q(q), .fb(fb)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] mode;
    logic [1:0] src;
    logic [1:0] cs;
    logic       ceU;
    logic       ce;
    logic       x;
    logic       t;
    logic       p;
    logic       a;
    logic       ex;
  } vec_t;

  localparam int NVEC = 20;
  // req, mode, src, clock, ceUse, ce, xor, term, pin, aux, expected q
  localparam vec_t VECS [0:NVEC-1] = '{
    '{4'd2, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 D load 1
    '{4'd9, 3'd0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 term source
    '{4'd9, 3'd0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R9 pin source
    '{4'd7, 3'd1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 term clock
    '{4'd3, 3'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 toggle
    '{4'd3, 3'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 hold
    '{4'd4, 3'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 K clears
    '{4'd4, 3'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 J sets
    '{4'd4, 3'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 toggle
    '{4'd4, 3'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 hold
    '{4'd5, 3'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 set
    '{4'd5, 3'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 hold
    '{4'd5, 3'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 both -> 0
    '{4'd8, 3'd3, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 blocked
    '{4'd8, 3'd3, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 enabled
    '{4'd8, 3'd0, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 term clk ignores ce
    '{4'd6, 3'd4, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 latch
    '{4'd9, 3'd0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 code 3
    '{4'd2, 3'd6, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 unused code
    '{4'd8, 3'd4, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}  // R8 latch closed
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic setClk(input int c, input logic v);
    if (c == NG) ptClk = v;
    else         gclk[c] = v;
  endtask

  task automatic pulse(input int c);
    @(negedge clk); setClk(c, 1'b1);
    @(posedge clk); #1;
    @(negedge clk); setClk(c, 1'b0);
    @(posedge clk); #1;
  endtask

  task automatic loadD(input logic v);
    @(negedge clk);
    modeSel = 3'd0; dataSrc = 2'd0; clkSel = 2'd0; ceUse = 1'b0; xorIn = v;
    pulse(0);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    logic refQ, d, en;
    int m, cs;
    string tag;

    // R1: reset with the selected clock held high
    gclk[0] = 1'b1; xorIn = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1", q, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1", q, 1'b0);
    chk("R13", fb, 1'b0);
    @(negedge clk); gclk[0] = 1'b0; xorIn = 1'b0;
    @(posedge clk);

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      @(negedge clk);
      modeSel = v.mode; dataSrc = v.src; clkSel = v.cs;
      ceUse = v.ceU; ceIn = v.ce;
      xorIn = v.x; termIn = v.t; pinIn = v.p; auxIn = v.a;
      pulse(int'(v.cs));
      total++;
      if (q !== v.ex) begin
        bad++;
        $display("FAIL R%0d vector %0d act=%b exp=%b", v.req, i, q, v.ex);
      end
    end

    // random phase against a reference model, with clear pulses
    refQ = VECS[NVEC-1].ex;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      m  = $urandom_range(0, 4);
      cs = $urandom_range(0, 3);
      modeSel = 3'(m); clkSel = 2'(cs);
      dataSrc = 2'($urandom_range(0, 3));
      ceUse = 1'($urandom_range(0, 1)); ceIn = 1'($urandom_range(0, 1));
      xorIn = 1'($urandom_range(0, 1)); termIn = 1'($urandom_range(0, 1));
      pinIn = 1'($urandom_range(0, 1)); auxIn = 1'($urandom_range(0, 1));
      pulse(cs);
      case (dataSrc)
        2'd1: d = termIn;
        2'd2: d = pinIn;
        default: d = xorIn;
      endcase
      en = (cs == NG) || !ceUse || ceIn;
      case (m)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R4";
        3: tag = "R5";
        default: tag = "R6";
      endcase
      if (en) begin
        case (m)
          1: refQ = refQ ^ d;
          2: refQ = (d && auxIn) ? ~refQ : (d ? 1'b1 : (auxIn ? 1'b0 : refQ));
          3: refQ = auxIn ? 1'b0 : (d ? 1'b1 : refQ);
          default: refQ = d;
        endcase
      end
      chk(tag, q, refQ);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk); clrSel = 2'd1; gClear = 1'b1;
        @(posedge clk); #1 chk("R10", q, 1'b0);
        @(negedge clk); gClear = 1'b0; clrSel = 2'd0;
        refQ = 1'b0;
      end
    end

    // R10: clock edge and clear in the same cycle
    loadD(1'b0);
    @(negedge clk); xorIn = 1'b1; clrSel = 2'd1; gClear = 1'b1; gclk[0] = 1'b1;
    #1 chk("R10", q, 1'b0);
    @(posedge clk); #1 chk("R10", q, 1'b0);
    @(negedge clk); gClear = 1'b0; gclk[0] = 1'b0;
    @(posedge clk); #1 chk("R10", q, 1'b0);

    // R10: disabled clear has no effect
    loadD(1'b1);
    @(negedge clk); clrSel = 2'd0; gClear = 1'b1;
    @(posedge clk); #1 chk("R10", q, 1'b1);
    @(negedge clk); gClear = 1'b0;

    // R10: term clear, and OR of both sources
    @(negedge clk); clrSel = 2'd2; clrTerm = 1'b1;
    #1 chk("R10", q, 1'b0);
    @(negedge clk); clrTerm = 1'b0;
    loadD(1'b1);
    @(negedge clk); clrSel = 2'd3; clrTerm = 1'b1;
    #1 chk("R10", q, 1'b0);
    @(negedge clk); clrTerm = 1'b0;
    loadD(1'b1);
    @(negedge clk); gClear = 1'b1;
    #1 chk("R10", q, 1'b0);
    @(negedge clk); gClear = 1'b0; clrSel = 2'd0;

    // R11: preset, then preset disabled
    @(negedge clk); preUse = 1'b1; preTerm = 1'b1;
    #1 chk("R11", q, 1'b1);
    @(negedge clk); preTerm = 1'b0;
    @(posedge clk); #1 chk("R11", q, 1'b1);
    loadD(1'b0);
    @(negedge clk); preUse = 1'b0; preTerm = 1'b1;
    @(posedge clk); #1 chk("R11", q, 1'b0);
    @(negedge clk); preTerm = 1'b0;

    // R12: clear and preset together
    @(negedge clk); clrSel = 2'd1; gClear = 1'b1; preUse = 1'b1; preTerm = 1'b1;
    #1 chk("R12", q, 1'b0);
    @(posedge clk); #1 chk("R12", q, 1'b0);
    @(negedge clk); gClear = 1'b0;
    #1 chk("R12", q, 1'b1);
    @(negedge clk); preTerm = 1'b0; preUse = 1'b0; clrSel = 2'd0;

    // R6: flow-through then hold
    loadD(1'b0);
    @(negedge clk); modeSel = 3'd4; xorIn = 1'b1; gclk[0] = 1'b1;
    #1 chk("R6", q, 1'b1);
    @(negedge clk); xorIn = 1'b0;
    #1 chk("R6", q, 1'b0);
    @(negedge clk); xorIn = 1'b1;
    #1 chk("R6", q, 1'b1);
    @(negedge clk); xorIn = 1'b0; gclk[0] = 1'b0;
    #1 chk("R6", q, 1'b1);
    repeat (2) @(posedge clk);
    #1 chk("R6", q, 1'b1);

    // R7: unselected clock has no effect
    @(negedge clk); modeSel = 3'd0; clkSel = 2'd1; xorIn = 1'b0;
    pulse(0);
    chk("R7", q, 1'b1);

    // R13: feedback selection
    @(negedge clk); fbSel = 1'b1; xorIn = 1'b0;
    #1 chk("R13", fb, 1'b0);
    @(negedge clk); xorIn = 1'b1;
    #1 chk("R13", fb, 1'b1);
    @(negedge clk); fbSel = 1'b0; xorIn = 1'b0;
    #1 chk("R13", fb, q);
    chk("R13", fb, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule